// File: doc/BRIEF.md
# Serial Port Control and Status Registers

This block is the register front end of a FIFO-based asynchronous serial port. A host reaches it over a simple synchronous bus that carries a byte-offset address. The block holds the mode, bit-rate, control, FIFO-control and port registers. It keeps the transmit and receive status flags and sends each byte written for transmission out on an 8-bit stream strobe. It drives two interrupt lines, one for receive data and one for transmit data. The block does not serialise bits or generate the baud rate. The receive FIFO storage sits outside the block, and the block reaches it through push, pop, flush, count and head-byte signals.

The transmit flags are tracked by a four-state machine, with one state for each combination of transmit-empty and transmit-end:

- `TXS_DONE`: both flags set.
- `TXS_LOADED`: both flags clear.
- `TXS_EMPTY`: only transmit-empty set.
- `TXS_ENDED`: only transmit-end set.

The transitions are:

- A transmit-data write clears transmit-empty: DONE to ENDED, EMPTY to LOADED.
- A control write with transmit-enable low sets transmit-end: LOADED to ENDED, EMPTY to DONE.
- A status write keeps only the flags written as 1.
- A status read while transmit-enable is high moves any state to DONE once the read value has been captured.

The receive flags and the receive interrupt live in a separate receive controller. That controller decides each push and pop against the external FIFO count.

Top module: `sc_serial_regs`

## Requirements
- R1: After reset the status reads 0x0060, bit-rate 0x00FF, control 0x0020, and mode, port, FIFO control and receive count 0. Both interrupts are low.
- R2: Registers sit at these offsets: mode 0x00, bit-rate 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, receive count 0x1C, port 0x20, line status 0x24. Writes are masked with 0x7B for mode, 0xFA for control and 0xF3 for port. Bit-rate keeps the low 8 bits and FIFO control keeps all 16.
- R3: Status bits are transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0; other bits read 0. A status write clears each flag whose bit is 0 and leaves each flag whose bit is 1 unchanged.
- R4: A status read returns the flags as they were before the read. If control bit 5 (transmit enable) is 1, transmit-empty and transmit-end are then both set. A control write with bit 5 at 0 sets transmit-end.
- R5: A transmit-data write raises tx_valid for exactly one cycle, on the cycle after the write, with tx_data equal to the low byte written. It also clears transmit-empty.
- R6: An incoming byte is pushed only while control bit 4 (receive enable) is 1 and the FIFO count is below its depth. Otherwise it is dropped.
- R7: Receive-full is set when a push brings the count up to the trigger level. FIFO-control bits 7:6 select the trigger: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. A pop that leaves the count below the trigger clears receive-full.
- R8: rx_irq rises when a push sets receive-full while control bit 6 is 1. It falls on a control write with bit 6 at 0, or on a status write that clears receive-full or data-ready. It does not fall on a pop.
- R9: tx_irq equals control bit 7.
- R10: A receive-data read returns the FIFO head byte and pops it when the count is non-zero. On an empty FIFO it returns 0 and does not pop. A receive-count read returns the count.
- R11: A FIFO-control write with bit 1 set pulses fifo_flush, clears receive-full and suppresses any push in that cycle. The written value is stored.
- R12: A brk_event pulse sets the break flag and an rx_stale pulse sets data-ready. If a set and a status-write clear arrive in the same cycle, the set wins.
- R13: Read data appears with bus_rvalid one cycle after bus_rd. Unmapped offsets and line status read 0 and ignore writes. A cycle with both bus_wr and bus_rd performs only the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_in_valid | input | 1 | Incoming byte strobe |
| rx_in_data | input | 8 | Incoming byte |
| brk_event | input | 1 | Break seen on the line |
| rx_stale | input | 1 | Data has waited below trigger |
| fifo_push | output | 1 | Push to receive FIFO |
| fifo_push_data | output | 8 | Byte to push |
| fifo_pop | output | 1 | Pop from receive FIFO |
| fifo_flush | output | 1 | Empty the receive FIFO |
| fifo_count | input | 5 | Receive FIFO fill level |
| fifo_head | input | 8 | Oldest FIFO byte |
| rx_irq | output | 1 | Receive-data interrupt |
| tx_irq | output | 1 | Transmit-data interrupt |

## Verification
A wrong transmit state shows up at the very next status read, which is one cycle after bus_rd. A wrong receive-full flag shows both in that status read and, when interrupts are enabled, on rx_irq in the cycle right after the push that should have crossed the trigger. Count and pop faults appear within one read of receive count or receive data, because the head byte returned then reveals a skipped or duplicated pop. Mask and decode faults appear on the first read-back of the written register.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int unsigned ADDR_W = 6;
    localparam int unsigned DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_MODE   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_RATE   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TXD    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RXD    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_FCTL   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RXCNT  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_PORT   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_LSTAT  = 6'h24;

    localparam logic [7:0] MODE_MASK = 8'h7B;
    localparam logic [7:0] CTRL_MASK = 8'hFA;
    localparam logic [7:0] PORT_MASK = 8'hF3;

    localparam logic [7:0] RATE_RST = 8'hFF;
    localparam logic [7:0] CTRL_RST = 8'h20;

    // control bit positions
    localparam int unsigned CB_RE  = 4;
    localparam int unsigned CB_TE  = 5;
    localparam int unsigned CB_RIE = 6;
    localparam int unsigned CB_TIE = 7;

    // status bit positions
    localparam int unsigned SB_TEND = 6;
    localparam int unsigned SB_TDE  = 5;
    localparam int unsigned SB_BRK  = 4;
    localparam int unsigned SB_RDF  = 1;
    localparam int unsigned SB_DR   = 0;

    typedef enum logic [1:0] {
        TXS_DONE   = 2'd0,
        TXS_LOADED = 2'd1,
        TXS_EMPTY  = 2'd2,
        TXS_ENDED  = 2'd3
    } tx_state_e;

    function automatic tx_state_e tx_from_flags(input logic tde, input logic tend);
        unique case ({tde, tend})
            2'b11:   return TXS_DONE;
            2'b10:   return TXS_EMPTY;
            2'b01:   return TXS_ENDED;
            default: return TXS_LOADED;
        endcase
    endfunction

    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        int unsigned lvl;
        unique case (sel)
            2'd0:    lvl = 1;
            2'd1:    lvl = 4;
            2'd2:    lvl = 8;
            default: lvl = 14;
        endcase
        return (lvl > depth) ? depth : lvl;
    endfunction

    function automatic logic ofs_mapped(input logic [ADDR_W-1:0] a);
        return (a == OFS_MODE) || (a == OFS_RATE) || (a == OFS_CTRL) ||
               (a == OFS_TXD)  || (a == OFS_STAT) || (a == OFS_RXD)  ||
               (a == OFS_FCTL) || (a == OFS_RXCNT) || (a == OFS_PORT) ||
               (a == OFS_LSTAT);
    endfunction

endpackage

// File: rtl/sc_cfg_regs.sv
module sc_cfg_regs
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic              wr_rate,
    input  logic              wr_ctrl,
    input  logic              wr_fctl,
    input  logic              wr_port,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        mode_q,
    output logic [7:0]        rate_q,
    output logic [7:0]        ctrl_q,
    output logic [DATA_W-1:0] fctl_q,
    output logic [7:0]        port_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            rate_q <= RATE_RST;
            ctrl_q <= CTRL_RST;
            fctl_q <= '0;
            port_q <= '0;
        end else begin
            if (wr_mode) mode_q <= wdata[7:0] & MODE_MASK;
            if (wr_rate) rate_q <= wdata[7:0];
            if (wr_ctrl) ctrl_q <= wdata[7:0] & CTRL_MASK;
            if (wr_fctl) fctl_q <= wdata;
            if (wr_port) port_q <= wdata[7:0] & PORT_MASK;
        end
    end

endmodule

// File: rtl/sc_tx_flags.sv
module sc_tx_flags
    import sc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txd_wr,
    input  logic [7:0] txd_byte,
    input  logic       ctrl_wr,
    input  logic       ctrl_te_w,
    input  logic       stat_wr,
    input  logic       keep_tde,
    input  logic       keep_tend,
    input  logic       stat_rd,
    input  logic       te,
    output logic       tde,
    output logic       tend,
    output logic       tx_valid,
    output logic [7:0] tx_data
);

    tx_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TXS_DONE;
        else        st_q <= st_d;
    end

    // transitions; the bus performs at most one access per cycle
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXS_DONE: begin
                if (txd_wr)       st_d = TXS_ENDED;
                else if (stat_wr) st_d = tx_from_flags(keep_tde, keep_tend);
            end
            TXS_LOADED: begin
                if (ctrl_wr && !ctrl_te_w) st_d = TXS_ENDED;
                else if (stat_rd && te)    st_d = TXS_DONE;
            end
            TXS_EMPTY: begin
                if (txd_wr)                st_d = TXS_LOADED;
                else if (ctrl_wr && !ctrl_te_w) st_d = TXS_DONE;
                else if (stat_wr)          st_d = tx_from_flags(keep_tde, 1'b0);
                else if (stat_rd && te)    st_d = TXS_DONE;
            end
            TXS_ENDED: begin
                if (stat_wr)               st_d = tx_from_flags(1'b0, keep_tend);
                else if (stat_rd && te)    st_d = TXS_DONE;
            end
            default: st_d = TXS_DONE;
        endcase
    end

    // flag outputs
    always_comb begin
        unique case (st_q)
            TXS_DONE:   begin tde = 1'b1; tend = 1'b1; end
            TXS_EMPTY:  begin tde = 1'b1; tend = 1'b0; end
            TXS_ENDED:  begin tde = 1'b0; tend = 1'b1; end
            default:    begin tde = 1'b0; tend = 1'b0; end
        endcase
    end

    // transmit stream strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= txd_wr;
            if (txd_wr) tx_data <= txd_byte;
        end
    end

endmodule

// File: rtl/sc_rx_ctrl.sv
module sc_rx_ctrl
    import sc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_in_valid,
    input  logic [7:0]    rx_in_data,
    input  logic          re,
    input  logic          rie,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] fifo_count,
    input  logic          rxd_rd,
    input  logic          flush,
    input  logic          brk_event,
    input  logic          rx_stale,
    input  logic          ctrl_wr,
    input  logic          ctrl_rie_w,
    input  logic          stat_wr,
    input  logic          keep_brk,
    input  logic          keep_rdf,
    input  logic          keep_dr,
    output logic          fifo_push,
    output logic [7:0]    fifo_push_data,
    output logic          fifo_pop,
    output logic          rdf,
    output logic          dr,
    output logic          brk,
    output logic          rx_irq
);

    localparam int unsigned EW = CW + 1;

    logic [EW-1:0] cnt_after;
    logic [EW-1:0] trig;
    logic          reach;
    logic          rdf_d, dr_d, brk_d, irq_d;

    assign trig           = EW'(trig_level(trig_sel, FIFO_DEPTH));
    assign fifo_push      = rx_in_valid && re && !flush && (fifo_count < CW'(FIFO_DEPTH));
    assign fifo_push_data = rx_in_data;
    assign fifo_pop       = rxd_rd && (fifo_count != '0);
    assign cnt_after      = {1'b0, fifo_count} + EW'(fifo_push) - EW'(fifo_pop);
    assign reach          = fifo_push && (cnt_after >= trig);

    always_comb begin
        rdf_d = rdf;
        if (stat_wr && !keep_rdf) rdf_d = 1'b0;
        if (flush)                          rdf_d = 1'b0;
        else if (reach)                     rdf_d = 1'b1;
        else if (fifo_pop && cnt_after < trig) rdf_d = 1'b0;

        dr_d = dr;
        if (stat_wr && !keep_dr) dr_d = 1'b0;
        if (rx_stale)            dr_d = 1'b1;

        brk_d = brk;
        if (stat_wr && !keep_brk) brk_d = 1'b0;
        if (brk_event)            brk_d = 1'b1;

        irq_d = rx_irq;
        if (ctrl_wr && !ctrl_rie_w)               irq_d = 1'b0;
        if (stat_wr && (!keep_rdf || !keep_dr))   irq_d = 1'b0;
        if (reach && rie)                         irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdf    <= 1'b0;
            dr     <= 1'b0;
            brk    <= 1'b0;
            rx_irq <= 1'b0;
        end else begin
            rdf    <= rdf_d;
            dr     <= dr_d;
            brk    <= brk_d;
            rx_irq <= irq_d;
        end
    end

endmodule

// File: rtl/sc_serial_regs.sv
module sc_serial_regs
    import sc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              rx_in_valid,
    input  logic [7:0]        rx_in_data,
    input  logic              brk_event,
    input  logic              rx_stale,
    output logic              fifo_push,
    output logic [7:0]        fifo_push_data,
    output logic              fifo_pop,
    output logic              fifo_flush,
    input  logic [CW-1:0]     fifo_count,
    input  logic [7:0]        fifo_head,
    output logic              rx_irq,
    output logic              tx_irq
);

    logic              rd;
    logic              w_mode, w_rate, w_ctrl, w_txd, w_stat, w_fctl, w_port;
    logic              r_stat, r_rxd;
    logic [7:0]        mode_q, rate_q, ctrl_q, port_q;
    logic [DATA_W-1:0] fctl_q;
    logic              tde, tend, rdf, dr, brk;
    logic [7:0]        stat_val;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    // decode: a write takes precedence over a read in the same cycle
    assign rd     = bus_rd && !bus_wr;
    assign w_mode = bus_wr && (bus_addr == OFS_MODE);
    assign w_rate = bus_wr && (bus_addr == OFS_RATE);
    assign w_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign w_txd  = bus_wr && (bus_addr == OFS_TXD);
    assign w_stat = bus_wr && (bus_addr == OFS_STAT);
    assign w_fctl = bus_wr && (bus_addr == OFS_FCTL);
    assign w_port = bus_wr && (bus_addr == OFS_PORT);
    assign r_stat = rd && (bus_addr == OFS_STAT);
    assign r_rxd  = rd && (bus_addr == OFS_RXD);

    assign fifo_flush = w_fctl && bus_wdata[1];

    sc_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (w_mode),
        .wr_rate (w_rate),
        .wr_ctrl (w_ctrl),
        .wr_fctl (w_fctl),
        .wr_port (w_port),
        .wdata   (bus_wdata),
        .mode_q  (mode_q),
        .rate_q  (rate_q),
        .ctrl_q  (ctrl_q),
        .fctl_q  (fctl_q),
        .port_q  (port_q)
    );

    sc_tx_flags u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .txd_wr    (w_txd),
        .txd_byte  (bus_wdata[7:0]),
        .ctrl_wr   (w_ctrl),
        .ctrl_te_w (bus_wdata[CB_TE]),
        .stat_wr   (w_stat),
        .keep_tde  (bus_wdata[SB_TDE]),
        .keep_tend (bus_wdata[SB_TEND]),
        .stat_rd   (r_stat),
        .te        (ctrl_q[CB_TE]),
        .tde       (tde),
        .tend      (tend),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    sc_rx_ctrl #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CW         (CW)
    ) u_rx (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_in_valid    (rx_in_valid),
        .rx_in_data     (rx_in_data),
        .re             (ctrl_q[CB_RE]),
        .rie            (ctrl_q[CB_RIE]),
        .trig_sel       (fctl_q[7:6]),
        .fifo_count     (fifo_count),
        .rxd_rd         (r_rxd),
        .flush          (fifo_flush),
        .brk_event      (brk_event),
        .rx_stale       (rx_stale),
        .ctrl_wr        (w_ctrl),
        .ctrl_rie_w     (bus_wdata[CB_RIE]),
        .stat_wr        (w_stat),
        .keep_brk       (bus_wdata[SB_BRK]),
        .keep_rdf       (bus_wdata[SB_RDF]),
        .keep_dr        (bus_wdata[SB_DR]),
        .fifo_push      (fifo_push),
        .fifo_push_data (fifo_push_data),
        .fifo_pop       (fifo_pop),
        .rdf            (rdf),
        .dr             (dr),
        .brk            (brk),
        .rx_irq         (rx_irq)
    );

    assign tx_irq = ctrl_q[CB_TIE];

    always_comb begin
        stat_val          = '0;
        stat_val[SB_TEND] = tend;
        stat_val[SB_TDE]  = tde;
        stat_val[SB_BRK]  = brk;
        stat_val[SB_RDF]  = rdf;
        stat_val[SB_DR]   = dr;
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_MODE:  rd_mux = DATA_W'(mode_q);
            OFS_RATE:  rd_mux = DATA_W'(rate_q);
            OFS_CTRL:  rd_mux = DATA_W'(ctrl_q);
            OFS_STAT:  rd_mux = DATA_W'(stat_val);
            OFS_RXD:   rd_mux = (fifo_count != '0) ? DATA_W'(fifo_head) : '0;
            OFS_FCTL:  rd_mux = fctl_q;
            OFS_RXCNT: rd_mux = DATA_W'(fifo_count);
            OFS_PORT:  rd_mux = DATA_W'(port_q);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            if (rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/sc_regs_chk.sv
module sc_regs_chk
    import sc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned CW         = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              rx_in_valid,
    input logic              fifo_push,
    input logic              fifo_pop,
    input logic              fifo_flush,
    input logic [CW-1:0]     fifo_count,
    input logic              rx_irq,
    input logic              tx_irq
);

    // R5
    tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_TXD) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

    // R5
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_TXD) |=> !tx_valid);

    // R9
    tx_irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=> (tx_irq == $past(bus_wdata[7])));

    // R10
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_count != '0));

    // R6
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (rx_in_valid && fifo_count < CW'(FIFO_DEPTH)));

    // R11
    flush_blocks_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> !fifo_push);

    // R13
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !ofs_mapped(bus_addr)) |=> (bus_rvalid && bus_rdata == '0));

    // R8
    rx_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && !bus_wdata[6] && !fifo_push) |=> !rx_irq);

endmodule

bind sc_serial_regs sc_regs_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CW         (CW)
) u_regs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .rx_in_valid (rx_in_valid),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .fifo_flush  (fifo_flush),
    .fifo_count  (fifo_count),
    .rx_irq      (rx_irq),
    .tx_irq      (tx_irq)
);

// File: tb/tb_sc_serial_regs.sv
module tb_sc_serial_regs;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    localparam logic [5:0] A_MODE = 6'h00, A_RATE = 6'h04, A_CTRL = 6'h08, A_TXD = 6'h0C,
                           A_STAT = 6'h10, A_RXD = 6'h14, A_FCTL = 6'h18, A_CNT = 6'h1C,
                           A_PORT = 6'h20, A_LST = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        brk_event = 1'b0, rx_stale = 1'b0;
    logic        fifo_push, fifo_pop, fifo_flush;
    logic [7:0]  fifo_push_data;
    logic [CW-1:0] fifo_count;
    logic [7:0]  fifo_head;
    logic        rx_irq, tx_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [7:0]  tx_exp_q[$];

    always #10 clk = ~clk;

    sc_serial_regs #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_in_valid(rx_in_valid),
        .rx_in_data(rx_in_data), .brk_event(brk_event), .rx_stale(rx_stale),
        .fifo_push(fifo_push), .fifo_push_data(fifo_push_data), .fifo_pop(fifo_pop),
        .fifo_flush(fifo_flush), .fifo_count(fifo_count), .fifo_head(fifo_head),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    // receive FIFO model
    logic [7:0] fmem [DEPTH];
    logic [3:0] fwp, frp;
    logic [CW-1:0] fcnt;
    always_ff @(posedge clk) begin
        if (!rst_n || fifo_flush) begin
            fwp <= '0; frp <= '0; fcnt <= '0;
        end else begin
            if (fifo_push) begin
                fmem[fwp] <= fifo_push_data;
                fwp <= fwp + 4'd1;
            end
            if (fifo_pop) frp <= frp + 4'd1;
            fcnt <= fcnt + CW'(fifo_push) - CW'(fifo_pop);
        end
    end
    assign fifo_count = fcnt;
    assign fifo_head  = fmem[frp];

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitors
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (rd_exp_q.size() == 0) check(bus_rdata, 16'hxxxx, "R13 unexpected read");
            else check(bus_rdata, rd_exp_q.pop_front(), rd_tag_q.pop_front());
        end
        if (rst_n && tx_valid) begin
            if (tx_exp_q.size() == 0) check({8'h0, tx_data}, 16'hxxxx, "R5 unexpected tx");
            else check({8'h0, tx_data}, {8'h0, tx_exp_q.pop_front()}, "R5 tx byte");
        end
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic send(input logic [15:0] d);
        tx_exp_q.push_back(d[7:0]);
        wr(A_TXD, d);
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk); rx_in_valid = 1'b1; rx_in_data = b;
        @(negedge clk); rx_in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check({14'h0, rx_irq, tx_irq}, 16'h0, "R1 irqs after reset");
        rd(A_STAT, 16'h0060, "R1 status reset");
        rd(A_RATE, 16'h00FF, "R1 bitrate reset");
        rd(A_CTRL, 16'h0020, "R1 control reset");
        rd(A_MODE, 16'h0000, "R1 mode reset");
        rd(A_FCTL, 16'h0000, "R1 fifo control reset");
        rd(A_PORT, 16'h0000, "R1 port reset");
        rd(A_CNT,  16'h0000, "R1 count reset");

        // R2 masks
        wr(A_MODE, 16'hFFFF); rd(A_MODE, 16'h007B, "R2 mode mask");
        wr(A_PORT, 16'hFFFF); rd(A_PORT, 16'h00F3, "R2 port mask");
        wr(A_RATE, 16'h1234); rd(A_RATE, 16'h0034, "R2 bitrate byte");
        wr(A_CTRL, 16'h00FF); rd(A_CTRL, 16'h00FA, "R2 control mask");
        check({15'h0, tx_irq}, 16'h1, "R9 tx_irq follows bit 7 high");
        wr(A_CTRL, 16'h0020);
        check({15'h0, tx_irq}, 16'h0, "R9 tx_irq follows bit 7 low");

        // R5 / R4 transmit with enable
        send(16'h01A5);
        rd(A_STAT, 16'h0040, "R5 tde cleared by transmit write");
        rd(A_STAT, 16'h0060, "R4 status read re-sets flags");

        // R3 / R4 with transmit disabled
        wr(A_CTRL, 16'h0000);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, 16'h0000, "R3 write-zero clears");
        rd(A_STAT, 16'h0000, "R4 no re-set while disabled");
        wr(A_CTRL, 16'h0000);
        rd(A_STAT, 16'h0040, "R4 control write sets tend");
        send(16'h003C);
        rd(A_STAT, 16'h0040, "R5 tde stays clear");
        wr(A_STAT, 16'h0020);
        rd(A_STAT, 16'h0000, "R3 tend cleared by zero");
        @(negedge clk); brk_event = 1'b1; @(negedge clk); brk_event = 1'b0;
        rd(A_STAT, 16'h0010, "R12 break set");
        wr(A_STAT, 16'h0010);
        rd(A_STAT, 16'h0010, "R3 written one keeps flag");
        wr(A_STAT, 16'h00EF);
        rd(A_STAT, 16'h0000, "R3 break cleared");
        @(negedge clk); rx_stale = 1'b1; @(negedge clk); rx_stale = 1'b0;
        rd(A_STAT, 16'h0001, "R12 data-ready set");
        wr(A_STAT, 16'h00FE);
        rd(A_STAT, 16'h0000, "R3 data-ready cleared");

        // R7 / R8 receive with trigger 4
        wr(A_CTRL, 16'h0050);
        wr(A_FCTL, 16'h0040);
        rx(8'h11); rx(8'h22); rx(8'h33);
        check({15'h0, rx_irq}, 16'h0, "R8 no irq below trigger");
        rd(A_STAT, 16'h0040, "R7 below trigger");
        rx(8'h44);
        check({15'h0, rx_irq}, 16'h1, "R8 irq at trigger");
        rd(A_STAT, 16'h0042, "R7 receive-full at trigger");
        rd(A_CNT, 16'h0004, "R10 count four");
        rd(A_RXD, 16'h0011, "R10 head byte");
        rd(A_STAT, 16'h0040, "R7 pop below trigger clears");
        check({15'h0, rx_irq}, 16'h1, "R8 pop keeps irq");
        wr(A_STAT, 16'h00FF);
        check({15'h0, rx_irq}, 16'h1, "R8 ones keep irq");
        wr(A_STAT, 16'h00FD);
        check({15'h0, rx_irq}, 16'h0, "R8 status clear drops irq");

        rx(8'h55);
        check({15'h0, rx_irq}, 16'h1, "R8 irq again at trigger");
        wr(A_CTRL, 16'h0010);
        check({15'h0, rx_irq}, 16'h0, "R8 control bit 6 low drops irq");
        rx(8'h66);
        check({15'h0, rx_irq}, 16'h0, "R8 no irq with interrupt disabled");
        rd(A_STAT, 16'h0042, "R7 flag without irq");

        // R6 receive disabled, then overflow
        wr(A_CTRL, 16'h0000);
        rx(8'h77);
        rd(A_CNT, 16'h0005, "R6 byte dropped while disabled");
        wr(A_CTRL, 16'h0010);
        for (int i = 0; i < 11; i++) rx(8'h80 + 8'(i));
        rd(A_CNT, 16'h0010, "R6 fifo full");
        rx(8'h99);
        rd(A_CNT, 16'h0010, "R6 push dropped when full");
        rd(A_RXD, 16'h0022, "R10 order kept");

        // R11 flush, R10 empty read
        wr(A_FCTL, 16'h0002);
        rd(A_CNT, 16'h0000, "R11 flushed");
        rd(A_STAT, 16'h0040, "R11 receive-full cleared");
        rd(A_FCTL, 16'h0002, "R11 value stored");
        rd(A_RXD, 16'h0000, "R10 empty read zero");
        rd(A_CNT, 16'h0000, "R10 empty read no pop");

        // R13 unmapped
        wr(6'h3C, 16'hFFFF);
        wr(A_LST, 16'hFFFF);
        rd(6'h3C, 16'h0000, "R13 unmapped reads zero");
        rd(A_LST, 16'h0000, "R13 line status zero");
        rd(6'h0E, 16'h0000, "R13 misaligned zero");
        rd(A_CTRL, 16'h0010, "R13 writes ignored");

        // R7 other trigger levels
        wr(A_FCTL, 16'h00C2);
        for (int i = 0; i < 13; i++) rx(8'(i));
        rd(A_STAT, 16'h0040, "R7 below trigger 14");
        rx(8'hEE);
        rd(A_STAT, 16'h0042, "R7 trigger 14");
        wr(A_FCTL, 16'h0002);
        rd(A_STAT, 16'h0040, "R11 flush clears flag");
        rx(8'h01);
        rd(A_STAT, 16'h0042, "R7 trigger 1");
        wr(A_FCTL, 16'h0082);
        for (int i = 0; i < 7; i++) rx(8'(i));
        rd(A_STAT, 16'h0040, "R7 below trigger 8");
        rx(8'h08);
        rd(A_STAT, 16'h0042, "R7 trigger 8");

        repeat (3) @(negedge clk);
        check(16'(rd_exp_q.size() + tx_exp_q.size()), 16'h0, "R13 all results seen");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule